// File: doc/BRIEF.md
# SPI Inter-Frame Delay Timer

This block measures the quiet interval an SPI master must leave between raising chip-select at the end of one frame and lowering it for the next one. The master pulses `start` at the moment chip-select deasserts. The timer then counts down a number of system clocks, taken from a 2-bit prescaler code and a 4-bit scaler code. When that count has run out and the serial clock generator reports an active edge, the timer pulses `done`, which tells the master that the next frame may begin.

Two mode inputs choose where the delay comes from. With the free-running serial clock off, the programmed codes always set the delay. With the free-running serial clock on, the gap is cut to exactly one serial clock period, unless the timed-bus mode is also on; in that case the programmed codes apply again. In every mode the end of the gap is pushed out to the next active serial clock edge, so that a new frame always starts in step with the serial clock.

Top module: `spi_gap_timer`

## Requirements
- R1: The prescaler code decodes to an odd factor: code 0 gives 1, code 1 gives 3, code 2 gives 5, code 3 gives 7.
- R2: Scaler code n decodes to the factor 2^(n+1). For example, code 4 gives 32 and code 14 gives 32768.
- R3: When `cont_clk` is 0, the delay D in system clocks is the prescaler factor times the scaler factor. Call the clock edge that samples `start` high edge 0. `done` is then high in the cycle after the first edge k ≥ D+1 at which `sck_tick` is sampled high.
- R4: When `cont_clk` is 1 and `tsb_mode` is 0, D is SCK_DIV system clocks (4 by default), whatever values the prescaler and scaler codes hold.
- R5: When `cont_clk` and `tsb_mode` are both 1, D is the product of the prescaler and scaler factors.
- R6: `done` never rises unless `sck_tick` was high at the edge that set it. An expired count waits for the next tick.
- R7: `done` is high for exactly one cycle per gap, and `busy` is low from the cycle in which `done` is high.
- R8: A `start` pulse during an active count reloads the counter from the codes present at that moment, and the earlier count produces no `done`.
- R9: Synchronous active-high `rst` clears `busy` and `done`. A count that reset interrupts never produces `done`.
- R10: `busy` is high in the cycle after every `start` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_code | input | PRE_W (2) | Prescaler selection code |
| scl_code | input | SCL_W (4) | Scaler selection code |
| cont_clk | input | 1 | Free-running serial clock mode |
| tsb_mode | input | 1 | Timed-bus mode; restores the programmed delay in free-running mode |
| start | input | 1 | Pulse at chip-select deassertion |
| sck_tick | input | 1 | Marks a cycle that holds an active serial clock edge |
| done | output | 1 | Single-cycle pulse: the next frame may begin |
| busy | output | 1 | A gap is being timed |

## Verification
The assertions check on every cycle the properties that do not depend on the codes. The decoded prescaler is odd and the decoded scaler is a single power of two. `busy` follows every `start`, and the counter reloads on `start` and only falls while it runs. `done` lasts one cycle, needs a tick and clears `busy`, and reset leaves everything idle. Only the bench scenarios can show the exact number of clocks for each code pair and mode. They also show that free-running mode ignores the codes, that different tick spacings stretch the gap to the correct edge, that a restart moves `done` to the new deadline, and that an interrupted count stays silent.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

  // Odd prescaler factor: 1, 3, 5, 7, ...
  function automatic int unsigned pre_factor(input int unsigned code);
    return 2 * code + 1;
  endfunction

  // Power-of-two scaler factor: 2, 4, 8, ...
  function automatic int unsigned scl_factor(input int unsigned code);
    return 32'd1 << (code + 1);
  endfunction

  // Largest delay the codes can select, for sizing the counter
  function automatic int unsigned max_gap(input int unsigned pre_w, input int unsigned scl_w);
    return pre_factor((1 << pre_w) - 1) * scl_factor((1 << scl_w) - 1);
  endfunction

endpackage

// File: rtl/spi_gap_decode.sv
module spi_gap_decode #(
  parameter int unsigned PRE_W   = 2,
  parameter int unsigned SCL_W   = 4,
  parameter int unsigned SCK_DIV = 4,
  parameter int unsigned CNT_W   = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  input  logic             cont_clk,
  input  logic             tsb_mode,
  output logic [CNT_W-1:0] load_val
);
  import spi_gap_pkg::*;

  logic [CNT_W-1:0] pre_val;
  logic [CNT_W-1:0] scl_val;
  logic [CNT_W-1:0] prog_gap;
  logic             fixed_sel;

  always_comb begin
    pre_val   = CNT_W'(pre_factor(int'(pre_code)));
    scl_val   = CNT_W'(scl_factor(int'(scl_code)));
    prog_gap  = CNT_W'(pre_factor(int'(pre_code)) * scl_factor(int'(scl_code)));
    fixed_sel = cont_clk && !tsb_mode;
    load_val  = fixed_sel ? CNT_W'(SCK_DIV) : prog_gap;
  end

  // R1: prescaler factor is always odd
  a_r1_pre_odd: assert property (@(posedge clk) disable iff (rst) pre_val[0]);
  // R2: scaler factor is a single power of two
  a_r2_scl_pow2: assert property (@(posedge clk) disable iff (rst) $countones(scl_val) == 1);

endmodule

// File: rtl/spi_gap_counter.sv
module spi_gap_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             fire,
  output logic             busy,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= load_val;
      busy  <= 1'b1;
    end else if (fire) begin
      busy  <= 1'b0;
    end else if (busy && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = busy && (cnt_q == '0);

  // R8: start reloads the counter from the decoded value
  a_r8_restart_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == $past(load_val));
  // R3: a running count only falls
  a_r3_count_falls: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && !fire && cnt_q != '0) |=> cnt_q < $past(cnt_q));
  // R10: busy follows start
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

endmodule

// File: rtl/spi_gap_align.sv
module spi_gap_align (
  input  logic clk,
  input  logic rst,
  input  logic expired,
  input  logic sck_tick,
  input  logic start,
  output logic fire,
  output logic done
);
  assign fire = expired && sck_tick && !start;

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= fire;
  end

  // R6: done needs an active SCK edge at its setting edge
  a_r6_done_on_tick: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(sck_tick));
  // R7: single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int unsigned PRE_W   = 2,
  parameter int unsigned SCL_W   = 4,
  parameter int unsigned SCK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  input  logic             cont_clk,
  input  logic             tsb_mode,
  input  logic             start,
  input  logic             sck_tick,
  output logic             done,
  output logic             busy
);
  import spi_gap_pkg::*;

  localparam int unsigned MAX_PROG = max_gap(PRE_W, SCL_W);
  localparam int unsigned MAX_GAP  = (MAX_PROG > SCK_DIV) ? MAX_PROG : SCK_DIV;
  localparam int unsigned CNT_W    = $clog2(MAX_GAP + 1);

  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic             fire;

  spi_gap_decode #(
    .PRE_W(PRE_W), .SCL_W(SCL_W), .SCK_DIV(SCK_DIV), .CNT_W(CNT_W)
  ) u_decode (
    .clk(clk), .rst(rst),
    .pre_code(pre_code), .scl_code(scl_code),
    .cont_clk(cont_clk), .tsb_mode(tsb_mode),
    .load_val(load_val)
  );

  spi_gap_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .start(start), .load_val(load_val),
    .fire(fire), .busy(busy), .expired(expired)
  );

  spi_gap_align u_align (
    .clk(clk), .rst(rst), .expired(expired), .sck_tick(sck_tick),
    .start(start), .fire(fire), .done(done)
  );

  // R7: busy is low while done is high
  a_r7_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: the cycle after reset is idle
  a_r9_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done));

endmodule

// File: tb/spi_gap_timer_bench.sv
`timescale 1ns/1ps
module spi_gap_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pre = '0;
  logic [3:0] scl = '0;
  logic       cont = 1'b0;
  logic       tsb = 1'b0;
  logic       start = 1'b0;
  logic       tick = 1'b0;
  logic       done;
  logic       busy;

  int n_total = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit ended   = 1'b0;

  always #2.5 clk = ~clk;

  spi_gap_timer u_spi_gap_timer (
    .clk(clk), .rst(rst), .pre_code(pre), .scl_code(scl),
    .cont_clk(cont), .tsb_mode(tsb), .start(start), .sck_tick(tick),
    .done(done), .busy(busy)
  );

  // {pre, scl, cont, tsb, tick period, expected done edge}
  typedef struct packed {
    logic [1:0]  p;
    logic [3:0]  s;
    logic        c;
    logic        t;
    logic [7:0]  per;
    logic [15:0] lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0, 1'b0, 1'b0, 8'd1, 16'd3},   // R1 R3: 1*2
    '{2'd1, 4'd0, 1'b0, 1'b0, 8'd1, 16'd7},   // R1: 3*2
    '{2'd2, 4'd1, 1'b0, 1'b0, 8'd1, 16'd21},  // R1 R2: 5*4
    '{2'd3, 4'd2, 1'b0, 1'b0, 8'd1, 16'd57},  // R1 R2: 7*8
    '{2'd1, 4'd4, 1'b0, 1'b0, 8'd1, 16'd97},  // R2: 3*32
    '{2'd3, 4'd5, 1'b1, 1'b0, 8'd1, 16'd5},   // R4: fixed 4
    '{2'd2, 4'd0, 1'b1, 1'b1, 8'd1, 16'd11},  // R5: 5*2
    '{2'd0, 4'd3, 1'b0, 1'b0, 8'd4, 16'd20},  // R6: 16 -> edge 20
    '{2'd1, 4'd1, 1'b0, 1'b0, 8'd4, 16'd16},  // R6: 12 -> edge 16
    '{2'd1, 4'd0, 1'b0, 1'b0, 8'd3, 16'd9},   // R6: 6 -> edge 9
    '{2'd3, 4'd0, 1'b1, 1'b0, 8'd4, 16'd8},   // R4 R6: 4 -> edge 8
    '{2'd0, 4'd3, 1'b0, 1'b0, 8'd2, 16'd18}   // R6: 16 -> edge 18
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  task automatic run_gap(input logic [1:0] p, input logic [3:0] s, input logic c,
                         input logic t, input int per, input int exp_lat, input string req);
    int seen_at;
    int pulses;
    @(negedge clk);
    pre = p; scl = s; cont = c; tsb = t; start = 1'b1; tick = 1'b0;
    @(posedge clk);
    seen_at = -1;
    pulses  = 0;
    for (int k = 1; k <= exp_lat + 3; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k >= 2 && done) begin
        pulses++;
        if (seen_at < 0) seen_at = k - 1;
      end
      if (k == 2) chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
      tick = ((k % per) == 0);
      @(posedge clk);
    end
    @(negedge clk);
    tick = 1'b0;
    chk(seen_at == exp_lat, req, seen_at, exp_lat);
    chk(pulses == 1, "R7 single done pulse", pulses, 1);
    chk(busy == 1'b0, "R7 busy low after done", int'(busy), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(done == 1'b0, "R9 reset done", int'(done), 0);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      run_gap(VECS[i].p, VECS[i].s, VECS[i].c, VECS[i].t,
              int'(VECS[i].per), int'(VECS[i].lat), "R3 done edge");
    end

    // R2: large scaler code 14 -> 32768, times 3
    run_gap(2'd1, 4'd14, 1'b0, 1'b0, 1, 98305, "R2 code 14 delay");

    // R8: restart at edge 3 with a 2-clock gap -> done at edge 6
    begin
      int seen_at;
      int pulses;
      @(negedge clk);
      pre = 2'd1; scl = 4'd0; cont = 1'b0; tsb = 1'b0; start = 1'b1; tick = 1'b1;
      @(posedge clk);
      seen_at = -1;
      pulses  = 0;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        start = (k == 3);
        if (k == 3) pre = 2'd0;
        if (k >= 2 && done) begin
          pulses++;
          if (seen_at < 0) seen_at = k - 1;
        end
        @(posedge clk);
      end
      @(negedge clk);
      tick = 1'b0;
      chk(seen_at == 6, "R8 restart done edge", seen_at, 6);
      chk(pulses == 1, "R8 old count silent", pulses, 1);
    end

    // R9: reset during a count, then ticks: no done
    begin
      int pulses;
      @(negedge clk);
      pre = 2'd3; scl = 4'd2; start = 1'b1; tick = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(busy == 1'b0, "R9 busy after mid reset", int'(busy), 0);
      pulses = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done) pulses++;
      end
      tick = 1'b0;
      chk(pulses == 0, "R9 no done after reset", pulses, 0);
    end

    // R4: codes held at maximum are ignored in free-running mode
    run_gap(2'd3, 4'd15, 1'b1, 1'b0, 1, 5, "R4 fields ignored");

    finish_run();
  end
endmodule